// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Error Status

This block sits between the receive shift register of a serial port and a processor-facing register read port. Each time the shift register finishes a character, it offers the assembled byte together with two status bits. One bit says the first stop bit was sampled low. The other says the parity check failed. The block queues up to two such characters, oldest first. It keeps each character's error status attached to that character, so software always sees the status of the byte it is about to read.

A third character can wait in a holding slot, which stands for the shift register still holding its finished byte. It moves into the queue at the clock edge that frees an entry. Suppose the queue is full, the holding slot is occupied, and another start bit is detected. The next character then has nowhere to go. That is an overrun. The overrun mark is stored with the held character, the last good one before the loss, so software sees it when it reads that character. Any read of the data register consumes the head entry. Dropping the receiver enable empties everything.

Top module: `rx_char_buffer`

## Requirements
- R1: Up to two characters are kept in arrival order; `rdData` shows the oldest, and a read strobe removes it at the next rising edge so the following character appears.
- R2: Offered data is masked at capture by `charWidth`: 0 keeps bits 4:0, 1 keeps bits 5:0, 2 keeps bits 6:0, 3 keeps all 8 bits; all other bits read as zero.
- R3: `rxComplete` is high exactly when at least one unread character is queued, and it can only rise at the edge after a character was offered.
- R4: With `rxEnable` low, the queue and the holding slot are emptied at the next edge and offered characters are ignored; after re-enabling, no earlier character reappears.
- R5: `frameErr` shows the stop-bit status of the head character: 1 when that character was offered with `shiftFrameErr`=1, 0 otherwise.
- R6: `parityErr` shows the parity status of the head character in the same way, taken from `shiftParityErr`.
- R7: Head data and all three flags stay unchanged while no read occurs; after a read they show the next character's values.
- R8: A character offered while both entries are full is held, and it enters the queue at the same edge where a read frees an entry.
- R9: A start-bit pulse while both entries are full and the holding slot is occupied marks the held character with overrun; `overrun` reads 1 while that character is at the head, and 0 for earlier characters.
- R10: A character offered while the queue is full and the holding slot is occupied is discarded.
- R11: `rxIrq` equals `rxComplete` AND `rxIntEnable`.
- R12: While the queue is empty, `rdData`, `frameErr`, `overrun` and `parityErr` all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receiver enable; low flushes the buffer |
| charWidth | input | 2 | Character size select, 0..3 for 5..8 bits |
| shiftValid | input | 1 | One-cycle pulse: a character is complete in the shift register |
| shiftData | input | 8 | Assembled character bits |
| shiftFrameErr | input | 1 | Stop bit of this character was sampled low |
| shiftParityErr | input | 1 | Parity check of this character failed |
| startDetect | input | 1 | One-cycle pulse: a new start bit was detected |
| rdStrobe | input | 1 | Data register read; consumes the head entry |
| rxIntEnable | input | 1 | Receive-complete interrupt enable |
| rdData | output | 8 | Head character |
| rxComplete | output | 1 | At least one unread character is queued |
| frameErr | output | 1 | Frame error of the head character |
| overrun | output | 1 | Overrun mark of the head character |
| parityErr | output | 1 | Parity error of the head character |
| rxIrq | output | 1 | Receive-complete interrupt request |

## Verification
The interesting collision is a read that frees an entry in the same edge where the held character must move into the queue. The write position then depends on the pop happening at that same edge. The bench provokes it by filling both entries and the holding slot, then reading. It judges the result by reading on and confirming the held character reaches the head in order, still carrying its overrun mark. A second collision is a start-bit pulse followed by a further offered character while everything is full. The bench confirms this character never appears and that the overrun mark lands only on the held one.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  localparam int DATA_W  = 8;
  localparam int MIN_W   = 5;
  localparam int SEL_W   = 2;
  localparam int DEPTH   = 2;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(DEPTH);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              frameErr;
    logic              parityErr;
    logic              overrun;
  } rxChar_t;

  typedef struct packed {
    logic             flush;
    logic             pop;
    logic             pushIn;
    logic             pushPend;
    logic             loadPend;
    logic             setOvr;
    logic [IDX_W-1:0] wrIdx;
  } bufStrobe_t;

  function automatic logic [DATA_W-1:0] widthMask(input logic [SEL_W-1:0] sel);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < MIN_W + int'(sel));
    return m;
  endfunction
endpackage

// File: rtl/rx_buf_ctrl.sv
module rx_buf_ctrl
  import rx_buf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       shiftValid,
  input  logic       startDetect,
  input  logic       rdStrobe,
  output bufStrobe_t strobes,
  output logic       notEmpty
);
  logic [CNT_W-1:0] count;
  logic             pendValid;
  logic             space;
  logic [CNT_W-1:0] afterPop;

  always_comb begin
    strobes          = '0;
    strobes.flush    = !rxEnable;
    strobes.pop      = rxEnable && rdStrobe && (count != '0);
    afterPop         = count - CNT_W'(strobes.pop);
    space            = afterPop < CNT_W'(DEPTH);
    strobes.wrIdx    = afterPop[IDX_W-1:0];
    strobes.pushPend = rxEnable && pendValid && space;
    strobes.pushIn   = rxEnable && shiftValid && !pendValid && space;
    strobes.loadPend = rxEnable && shiftValid &&
                       (strobes.pushPend || (!pendValid && !space));
    strobes.setOvr   = rxEnable && startDetect && pendValid && !strobes.pushPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      pendValid <= 1'b0;
    end else if (strobes.flush) begin
      count     <= '0;
      pendValid <= 1'b0;
    end else begin
      count     <= afterPop + CNT_W'(strobes.pushIn || strobes.pushPend);
      pendValid <= strobes.loadPend || (pendValid && !strobes.pushPend);
    end
  end

  assign notEmpty = (count != '0);
endmodule

// File: rtl/rx_buf_datapath.sv
module rx_buf_datapath
  import rx_buf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  bufStrobe_t strobes,
  input  rxChar_t    inChar,
  output rxChar_t    headChar
);
  rxChar_t slot [DEPTH];
  rxChar_t pend;
  rxChar_t newEntry;

  assign newEntry = strobes.pushPend ? pend : inChar;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slot[g] <= '0;
      end else if (!strobes.flush) begin
        if ((strobes.pushIn || strobes.pushPend) && strobes.wrIdx == IDX_W'(g))
          slot[g] <= newEntry;
        else if (strobes.pop && g < DEPTH - 1)
          slot[g] <= slot[(g < DEPTH - 1) ? g + 1 : g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pend <= '0;
    else if (strobes.flush)    pend <= '0;
    else if (strobes.loadPend) pend <= inChar;
    else if (strobes.setOvr)   pend.overrun <= 1'b1;
  end

  assign headChar = slot[0];
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rx_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic [SEL_W-1:0]  charWidth,
  input  logic              shiftValid,
  input  logic [DATA_W-1:0] shiftData,
  input  logic              shiftFrameErr,
  input  logic              shiftParityErr,
  input  logic              startDetect,
  input  logic              rdStrobe,
  input  logic              rxIntEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              rxComplete,
  output logic              frameErr,
  output logic              overrun,
  output logic              parityErr,
  output logic              rxIrq
);
  bufStrobe_t strobes;
  rxChar_t    inChar;
  rxChar_t    headChar;
  logic       notEmpty;

  always_comb begin
    inChar.data      = shiftData & widthMask(charWidth);
    inChar.frameErr  = shiftFrameErr;
    inChar.parityErr = shiftParityErr;
    inChar.overrun   = 1'b0;
  end

  rx_buf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .shiftValid(shiftValid),
    .startDetect(startDetect), .rdStrobe(rdStrobe),
    .strobes(strobes), .notEmpty(notEmpty)
  );

  rx_buf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inChar(inChar), .headChar(headChar)
  );

  assign rxComplete = notEmpty;
  assign rdData     = notEmpty ? headChar.data : '0;
  assign frameErr   = notEmpty && headChar.frameErr;
  assign parityErr  = notEmpty && headChar.parityErr;
  assign overrun    = notEmpty && headChar.overrun;
  assign rxIrq      = notEmpty && rxIntEnable;
endmodule

// File: rtl/rx_buf_checker.sv
module rx_buf_checker
  import rx_buf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              shiftValid,
  input logic              rdStrobe,
  input logic              rxIntEnable,
  input logic [DATA_W-1:0] rdData,
  input logic              rxComplete,
  input logic              frameErr,
  input logic              overrun,
  input logic              parityErr,
  input logic              rxIrq
);
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxComplete);

  a_r3_rise_needs_offer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxComplete) |-> $past(shiftValid && rxEnable));

  a_r7_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && rxComplete && !rdStrobe) |=>
      (!rxEnable || ($stable(rdData) && $stable(frameErr) &&
                     $stable(parityErr) && $stable(overrun))));

  a_r12_quiet_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !rxComplete |-> (rdData == '0 && !frameErr && !overrun && !parityErr));

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (rxComplete && rxIntEnable));
endmodule

bind rx_char_buffer rx_buf_checker u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .shiftValid(shiftValid),
  .rdStrobe(rdStrobe), .rxIntEnable(rxIntEnable), .rdData(rdData),
  .rxComplete(rxComplete), .frameErr(frameErr), .overrun(overrun),
  .parityErr(parityErr), .rxIrq(rxIrq)
);

// File: tb/rx_char_buffer_bench.sv
`timescale 1ns/1ps
module rx_char_buffer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b1;
  logic [1:0] charWidth = 2'd3;
  logic       shiftValid = 1'b0;
  logic [7:0] shiftData = '0;
  logic       shiftFrameErr = 1'b0;
  logic       shiftParityErr = 1'b0;
  logic       startDetect = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       rxIntEnable = 1'b0;
  logic [7:0] rdData;
  logic       rxComplete, frameErr, overrun, parityErr, rxIrq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rx_char_buffer u_rx_char_buffer (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .charWidth(charWidth),
    .shiftValid(shiftValid), .shiftData(shiftData), .shiftFrameErr(shiftFrameErr),
    .shiftParityErr(shiftParityErr), .startDetect(startDetect), .rdStrobe(rdStrobe),
    .rxIntEnable(rxIntEnable), .rdData(rdData), .rxComplete(rxComplete),
    .frameErr(frameErr), .overrun(overrun), .parityErr(parityErr), .rxIrq(rxIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk);
    shiftData = d; shiftFrameErr = fe; shiftParityErr = pe; shiftValid = 1'b1;
    @(negedge clk);
    shiftValid = 1'b0; shiftFrameErr = 1'b0; shiftParityErr = 1'b0;
  endtask

  task automatic readOne();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic startBit();
    @(negedge clk); startDetect = 1'b1;
    @(negedge clk); startDetect = 1'b0;
  endtask

  task automatic testReset();
    chk("R3 reset rxComplete", {7'd0, rxComplete}, 8'd0);
    chk("R12 reset rdData", rdData, 8'd0);
    chk("R11 reset rxIrq", {7'd0, rxIrq}, 8'd0);
  endtask

  task automatic testOrder();
    offer(8'hA5, 0, 0);
    chk("R3 one char", {7'd0, rxComplete}, 8'd1);
    offer(8'h3C, 0, 0);
    chk("R1 head oldest", rdData, 8'hA5);
    readOne();
    chk("R1 next after read", rdData, 8'h3C);
    chk("R3 still one", {7'd0, rxComplete}, 8'd1);
    readOne();
    chk("R3 empty", {7'd0, rxComplete}, 8'd0);
    chk("R12 data zero empty", rdData, 8'd0);
  endtask

  task automatic testMask();
    for (int w = 0; w < 4; w++) begin
      charWidth = 2'(w);
      offer(8'hFF, 0, 0);
      chk($sformatf("R2 width sel %0d", w), rdData, 8'((1 << (5 + w)) - 1));
      readOne();
    end
    charWidth = 2'd3;
  endtask

  task automatic testFlags();
    offer(8'h11, 1, 0);
    offer(8'h22, 0, 1);
    chk("R5 head frame err", {7'd0, frameErr}, 8'd1);
    chk("R6 head parity clean", {7'd0, parityErr}, 8'd0);
    repeat (3) @(negedge clk);
    chk("R7 frame err held", {7'd0, frameErr}, 8'd1);
    chk("R7 data held", rdData, 8'h11);
    readOne();
    chk("R7 next frame err", {7'd0, frameErr}, 8'd0);
    chk("R6 next parity err", {7'd0, parityErr}, 8'd1);
    readOne();
    chk("R12 flags zero empty", {5'd0, frameErr, parityErr, overrun}, 8'd0);
  endtask

  task automatic testOverrun();
    offer(8'h01, 0, 0);
    offer(8'h02, 0, 0);
    offer(8'h03, 0, 0);
    startBit();
    offer(8'h04, 0, 0);
    chk("R9 first char clean", {7'd0, overrun}, 8'd0);
    chk("R8 head unchanged", rdData, 8'h01);
    readOne();
    chk("R9 second char clean", {7'd0, overrun}, 8'd0);
    chk("R8 second char", rdData, 8'h02);
    readOne();
    chk("R8 held char entered", rdData, 8'h03);
    chk("R9 overrun on held", {7'd0, overrun}, 8'd1);
    readOne();
    chk("R10 lost char absent", {7'd0, rxComplete}, 8'd0);
  endtask

  task automatic testFlush();
    offer(8'h0A, 0, 0);
    offer(8'h0B, 0, 0);
    offer(8'h0C, 0, 0);
    @(negedge clk); rxEnable = 1'b0;
    @(negedge clk);
    chk("R4 flushed", {7'd0, rxComplete}, 8'd0);
    offer(8'h0D, 0, 0);
    chk("R4 ignored while off", {7'd0, rxComplete}, 8'd0);
    @(negedge clk); rxEnable = 1'b1;
    @(negedge clk);
    chk("R4 empty after enable", {7'd0, rxComplete}, 8'd0);
    offer(8'h0E, 0, 0);
    chk("R4 fresh head", rdData, 8'h0E);
    readOne();
    chk("R4 no stale char", {7'd0, rxComplete}, 8'd0);
  endtask

  task automatic testIrq();
    rxIntEnable = 1'b0;
    offer(8'h55, 0, 0);
    chk("R11 masked", {7'd0, rxIrq}, 8'd0);
    @(negedge clk); rxIntEnable = 1'b1;
    #1;
    chk("R11 raised", {7'd0, rxIrq}, 8'd1);
    readOne();
    chk("R11 dropped empty", {7'd0, rxIrq}, 8'd0);
    rxIntEnable = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrder();
    testMask();
    testFlags();
    testOverrun();
    testFlush();
    testIrq();
    finishRun();
  end

  initial begin
    #50000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end
endmodule